// File: doc/BRIEF.md
# FIFO Trigger and Timeout Interrupt Unit

This block produces the interrupt and status view for the transmit and receive FIFOs of a serial engine. The FIFO storage is outside the block. The block takes the FIFO occupancy counts and flags and compares each count with a programmable trigger level. It also watches the receive side for two conditions: a word arriving while the FIFO is full (overrun), and a FIFO that holds data but has not been read for a while (timeout). The timeout is measured in ticks of a strobe that runs at twice the serial clock rate.

The interrupt sources form a four-bit vector:

| Bit | Source |
|-----|--------|
| 0 | overrun |
| 1 | timeout |
| 2 | RX trigger |
| 3 | TX trigger |

The same bit order holds for the enable, raw and masked views. The two trigger sources follow the FIFO levels directly. Overrun and timeout are sticky and are cleared by write-one-to-clear strobes. A masked vector and a single interrupt line come from the enables. An 8-bit status word and a 32-bit state word with the two counts are also provided.

Top module: `fifo_irq_unit`

## Requirements
- R1: Raw bit 3 and status bit 7 (TX trigger) are 1 exactly when `tx_count_i < tx_lvl_i`. They follow the inputs in the same cycle.
- R2: Raw bit 2 and status bit 6 (RX trigger) are 1 exactly when `rx_count_i >= rx_lvl_i`. They follow the inputs in the same cycle.
- R3: Raw bit 1 (timeout) becomes 1 after the clock edge that samples the 32nd `tick2x_i` since the counter last restarted, provided no pop, no timeout clear and no empty FIFO occurred in that window.
- R4: The timeout counter restarts from zero on any cycle with `rx_pop_i`, with `irq_clr_i[1]`, or with `rx_empty_i`. It does not count while the RX FIFO is empty.
- R5: Once set, the timeout bit holds until `irq_clr_i[1]` is pulsed, and it is 0 after that edge. The counter stops at 32 and does not wrap.
- R6: The overrun bit (raw bit 0) is set on the edge after a cycle with `rx_push_i` and `rx_full_i` both high. It holds until `irq_clr_i[0]` is pulsed. A new overrun in the same cycle as a clear wins, and the bit stays 1.
- R7: `irq_masked_o` equals `irq_raw_o & irq_en_i`, and `irq_o` is the OR of `irq_masked_o`. Both are valid in the same cycle.
- R8: The status bits are laid out as follows:

  | Bit | Meaning |
  |-----|---------|
  | 0 | TX empty |
  | 1 | TX not full |
  | 2 | RX not empty |
  | 3 | RX full |
  | 4 | busy |
  | 5 | first word |
  | 6 | RX trigger |
  | 7 | TX trigger |

  Each bit follows its input in the same cycle.
- R9: `state_o` holds the RX count in bits 15:8 and the TX count in bits 31:24. All other bits are zero.
- R10: After reset, both sticky bits and the timeout counter are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_count_i | input | CNT_W | TX FIFO occupancy |
| rx_count_i | input | CNT_W | RX FIFO occupancy |
| tx_empty_i | input | 1 | TX FIFO empty |
| tx_full_i | input | 1 | TX FIFO full |
| rx_empty_i | input | 1 | RX FIFO empty |
| rx_full_i | input | 1 | RX FIFO full |
| rx_push_i | input | 1 | Word arriving at the RX FIFO |
| rx_pop_i | input | 1 | RX FIFO read |
| tick2x_i | input | 1 | Strobe at twice the serial clock rate |
| busy_i | input | 1 | Serial engine busy |
| first_word_i | input | 1 | Head RX word was first of a frame |
| tx_lvl_i | input | CNT_W | TX trigger level |
| rx_lvl_i | input | CNT_W | RX trigger level |
| irq_en_i | input | 4 | Interrupt enables |
| irq_clr_i | input | 2 | Write-one-to-clear strobes: bit 0 overrun, bit 1 timeout |
| status_o | output | 8 | Status flags |
| state_o | output | 32 | FIFO counts |
| irq_raw_o | output | 4 | Raw interrupt vector |
| irq_masked_o | output | 4 | Enabled interrupt vector |
| irq_o | output | 1 | Interrupt line |

## Verification
The trigger bits, the status word, the state word, the masked vector and the interrupt line all come from combinational logic. The bench therefore changes inputs at the falling edge and checks these outputs 1 ns later, within the same cycle. The overrun and timeout bits are registered once, so each is due on the rising edge that samples its cause. For these, the bench checks at the falling edge after that rising edge. Timeout cases count exact tick numbers, checking at 31 ticks (still 0) and at 32 ticks (now 1).

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int unsigned IRQ_N   = 4;
  localparam int unsigned IRQ_OVR = 0;
  localparam int unsigned IRQ_TO  = 1;
  localparam int unsigned IRQ_RXT = 2;
  localparam int unsigned IRQ_TXT = 3;
endpackage

// File: rtl/fifo_irq_level.sv
module fifo_irq_level #(
  parameter int unsigned W           = 8,
  parameter bit          AT_OR_ABOVE = 1'b0
) (
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] level_i,
  output logic         hit_o
);
  generate
    if (AT_OR_ABOVE) begin : g_ge
      assign hit_o = (count_i >= level_i);
    end else begin : g_lt
      assign hit_o = (count_i < level_i);
    end
  endgenerate
endmodule

// File: rtl/fifo_irq_sticky.sv
module fifo_irq_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority so an event coincident with a clear is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/fifo_irq_timeout.sv
module fifo_irq_timeout #(
  parameter int unsigned TO_TICKS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_empty_i,
  input  logic rx_pop_i,
  input  logic clr_i,
  output logic flag_o
);
  localparam int unsigned CW = $clog2(TO_TICKS + 1);
  localparam logic [CW-1:0] SAT  = CW'(TO_TICKS);
  localparam logic [CW-1:0] LAST = CW'(TO_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          restart;
  logic          fire;

  assign restart = clr_i | rx_pop_i | rx_empty_i;
  assign fire    = !restart && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (restart)                     cnt_q <= '0;
      else if (tick_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
      if (clr_i)     flag_o <= 1'b0;
      else if (fire) flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fifo_irq_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned TO_TICKS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             tx_empty_i,
  input  logic             tx_full_i,
  input  logic             rx_empty_i,
  input  logic             rx_full_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             tick2x_i,
  input  logic             busy_i,
  input  logic             first_word_i,
  input  logic [CNT_W-1:0] tx_lvl_i,
  input  logic [CNT_W-1:0] rx_lvl_i,
  input  logic [3:0]       irq_en_i,
  input  logic [1:0]       irq_clr_i,
  output logic [7:0]       status_o,
  output logic [31:0]      state_o,
  output logic [3:0]       irq_raw_o,
  output logic [3:0]       irq_masked_o,
  output logic             irq_o
);
  logic tx_hit, rx_hit, to_flag, ovr_flag;

  fifo_irq_level #(.W(CNT_W), .AT_OR_ABOVE(1'b0)) i_tx_lvl (
    .count_i(tx_count_i), .level_i(tx_lvl_i), .hit_o(tx_hit)
  );
  fifo_irq_level #(.W(CNT_W), .AT_OR_ABOVE(1'b1)) i_rx_lvl (
    .count_i(rx_count_i), .level_i(rx_lvl_i), .hit_o(rx_hit)
  );
  fifo_irq_timeout #(.TO_TICKS(TO_TICKS)) i_to (
    .clk_i, .rst_ni, .tick_i(tick2x_i), .rx_empty_i, .rx_pop_i,
    .clr_i(irq_clr_i[IRQ_TO]), .flag_o(to_flag)
  );
  fifo_irq_sticky i_ovr (
    .clk_i, .rst_ni, .set_i(rx_push_i & rx_full_i),
    .clr_i(irq_clr_i[IRQ_OVR]), .flag_o(ovr_flag)
  );

  always_comb begin
    irq_raw_o          = '0;
    irq_raw_o[IRQ_OVR] = ovr_flag;
    irq_raw_o[IRQ_TO]  = to_flag;
    irq_raw_o[IRQ_RXT] = rx_hit;
    irq_raw_o[IRQ_TXT] = tx_hit;
  end

  assign irq_masked_o = irq_raw_o & irq_en_i;
  assign irq_o        = |irq_masked_o;

  assign status_o = {tx_hit, rx_hit, first_word_i, busy_i,
                     rx_full_i, !rx_empty_i, !tx_full_i, tx_empty_i};
  // counts wider than a byte are truncated
  assign state_o  = {8'(tx_count_i), 8'h00, 8'(rx_count_i), 8'h00};
endmodule

// File: rtl/fifo_irq_unit_chk.sv
module fifo_irq_unit_chk #(
  parameter int unsigned TO_TICKS = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_empty_i,
  input logic       rx_full_i,
  input logic       rx_push_i,
  input logic       rx_pop_i,
  input logic       tick2x_i,
  input logic [3:0] irq_en_i,
  input logic [1:0] irq_clr_i,
  input logic [7:0] status_o,
  input logic [3:0] irq_raw_o,
  input logic [3:0] irq_masked_o,
  input logic       irq_o
);
  localparam int unsigned CW = $clog2(TO_TICKS + 1);
  logic [CW-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else if (irq_clr_i[1] || rx_pop_i || rx_empty_i) win_q <= '0;
    else if (tick2x_i && win_q != CW'(TO_TICKS)) win_q <= win_q + 1'b1;
  end

  // R6
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && rx_full_i |=> irq_raw_o[0]);
  // R6
  ovr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_raw_o[0] && !irq_clr_i[0] |=> irq_raw_o[0]);
  // R6
  ovr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i[0] && !(rx_push_i && rx_full_i) |=> !irq_raw_o[0]);
  // R5
  to_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i[1] |=> !irq_raw_o[1]);
  // R5
  to_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_raw_o[1] && !irq_clr_i[1] |=> irq_raw_o[1]);
  // R4
  to_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_raw_o[1] && rx_empty_i |=> !irq_raw_o[1]);
  // R3
  to_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_raw_o[1]) |-> win_q == CW'(TO_TICKS));
  // R7
  mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_masked_o & ~irq_en_i) == 4'b0);
  // R7
  line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (irq_masked_o != 4'b0));
  // R1
  tx_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_raw_o[3] == status_o[7]);
  // R2
  rx_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_raw_o[2] == status_o[6]);
endmodule

bind fifo_irq_unit fifo_irq_unit_chk #(.TO_TICKS(TO_TICKS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_empty_i(rx_empty_i), .rx_full_i(rx_full_i),
  .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i), .tick2x_i(tick2x_i),
  .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i), .status_o(status_o),
  .irq_raw_o(irq_raw_o), .irq_masked_o(irq_masked_o), .irq_o(irq_o)
);

// File: tb/test_fifo_irq_unit.sv
module test_fifo_irq_unit;
  localparam int unsigned CNT_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [CNT_W-1:0] tx_count = '0, rx_count = '0, tx_lvl = '0, rx_lvl = 8'd1;
  logic tx_empty = 1'b0, tx_full = 1'b0, rx_empty = 1'b1, rx_full = 1'b0;
  logic rx_push = 1'b0, rx_pop = 1'b0, tick = 1'b0, busy = 1'b0, first = 1'b0;
  logic [3:0] irq_en = '0;
  logic [1:0] irq_clr = '0;
  logic [7:0] status;
  logic [31:0] state;
  logic [3:0] raw, masked;
  logic irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  fifo_irq_unit #(.CNT_W(CNT_W)) i_fifo_irq_unit (
    .clk_i(clk), .rst_ni(rst_ni), .tx_count_i(tx_count), .rx_count_i(rx_count),
    .tx_empty_i(tx_empty), .tx_full_i(tx_full), .rx_empty_i(rx_empty), .rx_full_i(rx_full),
    .rx_push_i(rx_push), .rx_pop_i(rx_pop), .tick2x_i(tick), .busy_i(busy),
    .first_word_i(first), .tx_lvl_i(tx_lvl), .rx_lvl_i(rx_lvl), .irq_en_i(irq_en),
    .irq_clr_i(irq_clr), .status_o(status), .state_o(state), .irq_raw_o(raw),
    .irq_masked_o(masked), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) step();
    tick = 1'b0;
  endtask

  task automatic clr_to();
    irq_clr = 2'b10;
    step();
    irq_clr = 2'b00;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R10 reset state
    chk("R10", {28'b0, raw}, 32'h0);
    chk("R10 line", {31'b0, irq}, 32'h0);
    step();

    // R1 R2 trigger sweep
    for (int c = 0; c <= 16; c++) begin
      for (int l = 0; l <= 16; l++) begin
        tx_count = 8'(c); rx_count = 8'(c); tx_lvl = 8'(l); rx_lvl = 8'(l);
        #1;
        chk("R1_R2 trig", {28'b0, raw[3], raw[2], status[7], status[6]},
            {28'b0, c < l, c >= l, c < l, c >= l});
        @(negedge clk);
      end
    end
    tx_lvl = '0; rx_lvl = 8'hff; tx_count = '0; rx_count = '0;

    // R8 status layout sweep
    for (int v = 0; v < 64; v++) begin
      {first, busy, rx_full, rx_empty, tx_full, tx_empty} = 6'(v);
      #1;
      chk("R8 status", {24'b0, status}, {24'b0, 2'b00, 6'(v) ^ 6'b000110});
      @(negedge clk);
    end
    {first, busy, rx_full, rx_empty, tx_full, tx_empty} = 6'b000100;

    // R9 state layout
    for (int c = 0; c < 16; c++) begin
      tx_count = 8'(c * 17); rx_count = 8'(255 - c * 13);
      #1;
      chk("R9 state", state, {8'(c * 17), 8'h00, 8'(255 - c * 13), 8'h00});
      @(negedge clk);
    end
    tx_count = '0; rx_count = 8'd3;

    // R3 basic timeout
    rx_empty = 1'b0;
    clr_to();
    ticks(31);
    chk("R3 31 ticks", {31'b0, raw[1]}, 0);
    ticks(1);
    chk("R3 32 ticks", {31'b0, raw[1]}, 1);
    // R5 saturation, stickiness and clear
    ticks(40);
    chk("R5 hold", {31'b0, raw[1]}, 1);
    clr_to();
    chk("R5 clear", {31'b0, raw[1]}, 0);
    ticks(31);
    chk("R5 restart 31", {31'b0, raw[1]}, 0);
    ticks(1);
    chk("R5 restart 32", {31'b0, raw[1]}, 1);

    // R4 pop restarts
    clr_to();
    ticks(20);
    rx_pop = 1'b1; tick = 1'b1; step(); rx_pop = 1'b0; tick = 1'b0;
    ticks(31);
    chk("R4 pop 31", {31'b0, raw[1]}, 0);
    ticks(1);
    chk("R4 pop 32", {31'b0, raw[1]}, 1);
    // R4 empty restarts and halts
    clr_to();
    ticks(20);
    rx_empty = 1'b1;
    ticks(40);
    chk("R4 empty idle", {31'b0, raw[1]}, 0);
    rx_empty = 1'b0;
    ticks(31);
    chk("R4 empty 31", {31'b0, raw[1]}, 0);
    ticks(1);
    chk("R4 empty 32", {31'b0, raw[1]}, 1);
    // R4 clear restarts mid-window
    clr_to();
    ticks(25);
    clr_to();
    ticks(31);
    chk("R4 clr 31", {31'b0, raw[1]}, 0);
    ticks(1);
    chk("R4 clr 32", {31'b0, raw[1]}, 1);

    // R6 overrun
    rx_push = 1'b1; rx_full = 1'b0; step(); rx_push = 1'b0;
    chk("R6 push not full", {31'b0, raw[0]}, 0);
    rx_push = 1'b1; rx_full = 1'b1; step(); rx_push = 1'b0;
    chk("R6 set", {31'b0, raw[0]}, 1);
    step(); step();
    chk("R6 sticky", {31'b0, raw[0]}, 1);
    rx_push = 1'b1; irq_clr = 2'b01; step(); rx_push = 1'b0; irq_clr = 2'b00;
    chk("R6 set beats clear", {31'b0, raw[0]}, 1);
    irq_clr = 2'b01; step(); irq_clr = 2'b00;
    chk("R6 clear", {31'b0, raw[0]}, 0);
    rx_push = 1'b1; step(); rx_push = 1'b0; rx_full = 1'b0;

    // R7 mask sweep, both sticky bits set
    for (int t = 0; t < 4; t++) begin
      for (int e = 0; e < 16; e++) begin
        logic [3:0] exp_raw;
        tx_lvl = (t[1]) ? 8'd1 : 8'd0; tx_count = '0;
        rx_lvl = (t[0]) ? 8'd0 : 8'd1; rx_count = '0;
        irq_en = 4'(e);
        exp_raw = {t[1] == 1'b1, t[0] == 1'b1, 2'b11};
        #1;
        chk("R7 raw", {28'b0, raw}, {28'b0, exp_raw});
        chk("R7 masked", {27'b0, irq, masked},
            {27'b0, (exp_raw & 4'(e)) != 0, exp_raw & 4'(e)});
        @(negedge clk);
      end
    end
    finish_run();
  end
endmodule